// File: doc/BRIEF.md
# CAN Receive Buffer Store Sequencer

This block takes a frame that the protocol engine has finished receiving and that acceptance filtering has already matched to one of 32 message buffers. It writes the frame into buffer RAM over a number of cycles. The frame consists of an 11-bit identifier, a 4-bit length code and up to eight data bytes. The block shares the single RAM port with the CPU, and the CPU always has priority on that port. For every buffer it keeps three flags: a new-data flag, an updating flag that is set while the store is in progress, and a ready flag that the CPU writes.

A store begins by setting both the new-data flag and the updating flag of the target buffer. It ends by setting the new-data flag a second time and clearing the updating flag. In the same cycle as the end of the store, a receive interrupt is pulsed. The buffer index is written into an eight-entry history FIFO at the start of the store, so software can see which buffer is being filled before the fill is finished. While a buffer is being updated, the CPU cannot change its ready flag or clear its new-data flag.

Top module: `canRxStoreSeq`

## Requirements
- R1: The block serves 32 buffers with indices 0 to 31. The RAM word address is {buffer index (5 bits, high), slot (4 bits, low)}.
- R2: If a request is accepted in cycle T, the new-data and updating flags of that buffer read 1 from cycle T+1.
- R3: The cycle after the final word write of a store, the buffer's new-data flag is 1 and its updating flag is 0. rxIrq is 1 in that cycle only.
- R4: The buffer index is pushed into the history FIFO when the request is accepted, so histValid/histIdx show it from T+1 while updating is still 1. Entries pop in arrival order on histPop.
- R5: A CPU ready-flag write to a buffer whose updating flag is 1 is ignored. Otherwise the written value appears the next cycle.
- R6: In any cycle with cpuRamReq=1, the RAM port carries the CPU's enable, write, address and data. The store word waits, and completion moves later by one cycle for each stalled cycle.
- R7: Store words are written one per cycle in ascending slot order. Slot 0 holds the identifier, zero-extended to 16 bits. Slot 1 holds the length code, zero-extended. Slot 2+k holds data byte k, which is reqData[8k+7:8k], in the low 8 bits.
- R8: The number of data bytes written is min(length code, 8), so a store writes 2+min(dlc,8) words.
- R9: A CPU new-data clear takes effect the next cycle, unless the buffer's updating flag is 1 or a request for that buffer is accepted in the same cycle. In those cases the flag stays 1.
- R10: A push into a history FIFO that already holds 8 entries is dropped, even if a pop happens in the same cycle. When a push is dropped, histOverflow is set, and it stays set until reset.
- R11: A request is accepted only while busy is 0. busy is 1 from T+1 through the final write cycle. A request made while busy is discarded and changes no flag or history entry.
- R12: After reset all flags are 0, the history FIFO is empty, histOverflow is 0, busy is 0 and rxIrq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Received frame ready for storing |
| reqIdx | input | 5 | Matched buffer index |
| reqId | input | 11 | Frame identifier |
| reqDlc | input | 4 | Frame length code |
| reqData | input | 64 | Data bytes, byte k at bits 8k+7:8k |
| busy | output | 1 | Store in progress |
| cpuRamReq | input | 1 | CPU uses the RAM port this cycle |
| cpuRamWe | input | 1 | CPU write enable |
| cpuRamAddr | input | 9 | CPU RAM address |
| cpuRamWdata | input | 16 | CPU write data |
| ramEn | output | 1 | RAM port enable |
| ramWe | output | 1 | RAM port write enable |
| ramAddr | output | 9 | RAM port address |
| ramWdata | output | 16 | RAM port write data |
| cpuRdyWe | input | 1 | CPU ready-flag write strobe |
| cpuRdyIdx | input | 5 | Buffer addressed by the ready write |
| cpuRdyVal | input | 1 | Ready value to write |
| cpuNdClr | input | 1 | CPU new-data clear strobe |
| cpuNdIdx | input | 5 | Buffer addressed by the clear |
| newData | output | 32 | New-data flag per buffer |
| updating | output | 32 | Updating flag per buffer |
| ready | output | 32 | Ready flag per buffer |
| histPop | input | 1 | Pop the history head |
| histValid | output | 1 | History FIFO not empty |
| histIdx | output | 5 | Buffer index at the history head |
| histOverflow | output | 1 | Sticky history drop flag |
| rxIrq | output | 1 | One-cycle receive interrupt |

## Verification
Two things can land on the same buffer in the same cycle. The first is a CPU flag access (a ready write or a new-data clear) that arrives while that buffer's store is still running. The second is CPU RAM traffic that overlaps store word writes. The bench raises a ready write, a new-data clear and a competing request all in the cycle right after acceptance. It judges the outcome at the flag outputs one cycle later and again after completion. Stall masks in the vector table assert cpuRamReq on chosen store cycles. The bench checks that the RAM port follows the CPU in those cycles and that the interrupt arrives exactly as many cycles later as there were stalls.

// File: rtl/canRxStorePkg.sv
package canRxStorePkg;
  localparam int SLOT_W = 4;

  typedef struct packed {
    logic              start;
    logic              wr;
    logic              finish;
    logic [SLOT_W-1:0] slot;
  } storeCmd_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_STORE = 1'b1} storeState_e;
endpackage

// File: rtl/canRxStoreCtrl.sv
module canRxStoreCtrl
  import canRxStorePkg::*;
#(
  parameter int DLC_W     = 4,
  parameter int MAX_BYTES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [DLC_W-1:0] reqDlc,
  input  logic             cpuRamReq,
  output storeCmd_t        cmd,
  output logic             busy
);
  localparam logic [DLC_W-1:0]  CAP      = DLC_W'(MAX_BYTES);
  localparam logic [SLOT_W-1:0] HDR_LAST = SLOT_W'(1);

  storeState_e       state;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] lastSlot;
  logic [DLC_W-1:0]  byteCnt;
  logic              accept;

  assign accept  = reqValid && (state == ST_IDLE);
  assign byteCnt = (reqDlc > CAP) ? CAP : reqDlc;

  always_comb begin
    cmd        = '0;
    cmd.start  = accept;
    cmd.wr     = (state == ST_STORE) && !cpuRamReq;
    cmd.finish = cmd.wr && (slot == lastSlot);
    cmd.slot   = slot;
  end

  assign busy = (state == ST_STORE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      slot     <= '0;
      lastSlot <= '0;
    end else if (accept) begin
      state    <= ST_STORE;
      slot     <= '0;
      lastSlot <= HDR_LAST + SLOT_W'(byteCnt);
    end else if (cmd.wr) begin
      slot <= slot + SLOT_W'(1);
      if (cmd.finish) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/canRxStoreDpath.sv
module canRxStoreDpath
  import canRxStorePkg::*;
#(
  parameter int NUM_BUF    = 32,
  parameter int ID_W       = 11,
  parameter int DLC_W      = 4,
  parameter int MAX_BYTES  = 8,
  parameter int WORD_W     = 16,
  parameter int HIST_DEPTH = 8,
  localparam int IDX_W     = $clog2(NUM_BUF),
  localparam int ADDR_W    = IDX_W + SLOT_W,
  localparam int DATA_W    = MAX_BYTES * 8,
  localparam int PTR_W     = $clog2(HIST_DEPTH),
  localparam int CNT_W     = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  storeCmd_t         cmd,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [ID_W-1:0]   reqId,
  input  logic [DLC_W-1:0]  reqDlc,
  input  logic [DATA_W-1:0] reqData,
  input  logic              cpuRamReq,
  input  logic              cpuRamWe,
  input  logic [ADDR_W-1:0] cpuRamAddr,
  input  logic [WORD_W-1:0] cpuRamWdata,
  output logic              ramEn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [WORD_W-1:0] ramWdata,
  input  logic              cpuRdyWe,
  input  logic [IDX_W-1:0]  cpuRdyIdx,
  input  logic              cpuRdyVal,
  input  logic              cpuNdClr,
  input  logic [IDX_W-1:0]  cpuNdIdx,
  output logic [NUM_BUF-1:0] newData,
  output logic [NUM_BUF-1:0] updating,
  output logic [NUM_BUF-1:0] ready,
  input  logic              histPop,
  output logic              histValid,
  output logic [IDX_W-1:0]  histIdx,
  output logic              histOverflow,
  output logic              rxIrq
);
  localparam logic [SLOT_W-1:0] SLOT_ID  = SLOT_W'(0);
  localparam logic [SLOT_W-1:0] SLOT_DLC = SLOT_W'(1);

  logic [IDX_W-1:0]  capIdx;
  logic [ID_W-1:0]   capId;
  logic [DLC_W-1:0]  capDlc;
  logic [DATA_W-1:0] capData;
  logic [2:0]        byteSel;
  logic [WORD_W-1:0] storeWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capIdx  <= '0;
      capId   <= '0;
      capDlc  <= '0;
      capData <= '0;
    end else if (cmd.start) begin
      capIdx  <= reqIdx;
      capId   <= reqId;
      capDlc  <= reqDlc;
      capData <= reqData;
    end
  end

  // Word assembly: identifier, then length code, then data bytes.
  assign byteSel = cmd.slot[2:0] - 3'd2;
  always_comb begin
    if (cmd.slot == SLOT_ID)       storeWord = WORD_W'(capId);
    else if (cmd.slot == SLOT_DLC) storeWord = WORD_W'(capDlc);
    else                           storeWord = WORD_W'(capData[byteSel*8 +: 8]);
  end

  // RAM port: the CPU always wins.
  always_comb begin
    if (cpuRamReq) begin
      ramEn    = 1'b1;
      ramWe    = cpuRamWe;
      ramAddr  = cpuRamAddr;
      ramWdata = cpuRamWdata;
    end else begin
      ramEn    = cmd.wr;
      ramWe    = cmd.wr;
      ramAddr  = {capIdx, cmd.slot};
      ramWdata = storeWord;
    end
  end

  // Per-buffer flag next state.
  logic [NUM_BUF-1:0] ndNext, mucNext, rdyNext;
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_flag
    logic startHit, finHit, ndClrHit, rdyHit;
    assign startHit = cmd.start && (reqIdx == IDX_W'(i));
    assign finHit   = cmd.finish && (capIdx == IDX_W'(i));
    assign ndClrHit = cpuNdClr && (cpuNdIdx == IDX_W'(i)) && !updating[i];
    assign rdyHit   = cpuRdyWe && (cpuRdyIdx == IDX_W'(i)) && !updating[i];
    assign ndNext[i]  = (startHit || finHit) ? 1'b1 : (ndClrHit ? 1'b0 : newData[i]);
    assign mucNext[i] = startHit ? 1'b1 : (finHit ? 1'b0 : updating[i]);
    assign rdyNext[i] = rdyHit ? cpuRdyVal : ready[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newData  <= '0;
      updating <= '0;
      ready    <= '0;
      rxIrq    <= 1'b0;
    end else begin
      newData  <= ndNext;
      updating <= mucNext;
      ready    <= rdyNext;
      rxIrq    <= cmd.finish;
    end
  end

  // History FIFO.
  logic [IDX_W-1:0] histMem [HIST_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] histCnt;
  logic             histFull, doPush, doPop;

  assign histFull  = (histCnt == CNT_W'(HIST_DEPTH));
  assign histValid = (histCnt != '0);
  assign histIdx   = histMem[rdPtr];
  assign doPush    = cmd.start && !histFull;
  assign doPop     = histPop && histValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      histCnt      <= '0;
      histOverflow <= 1'b0;
      for (int k = 0; k < HIST_DEPTH; k++) histMem[k] <= '0;
    end else begin
      if (doPush) begin
        histMem[wrPtr] <= reqIdx;
        wrPtr          <= wrPtr + PTR_W'(1);
      end
      if (doPop) rdPtr <= rdPtr + PTR_W'(1);
      if (cmd.start && histFull) histOverflow <= 1'b1;
      histCnt <= histCnt + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end
endmodule

// File: rtl/canRxStoreSeq.sv
module canRxStoreSeq
  import canRxStorePkg::*;
#(
  parameter int NUM_BUF    = 32,
  parameter int ID_W       = 11,
  parameter int DLC_W      = 4,
  parameter int MAX_BYTES  = 8,
  parameter int WORD_W     = 16,
  parameter int HIST_DEPTH = 8,
  localparam int IDX_W     = $clog2(NUM_BUF),
  localparam int ADDR_W    = IDX_W + SLOT_W,
  localparam int DATA_W    = MAX_BYTES * 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [IDX_W-1:0]   reqIdx,
  input  logic [ID_W-1:0]    reqId,
  input  logic [DLC_W-1:0]   reqDlc,
  input  logic [DATA_W-1:0]  reqData,
  output logic               busy,
  input  logic               cpuRamReq,
  input  logic               cpuRamWe,
  input  logic [ADDR_W-1:0]  cpuRamAddr,
  input  logic [WORD_W-1:0]  cpuRamWdata,
  output logic               ramEn,
  output logic               ramWe,
  output logic [ADDR_W-1:0]  ramAddr,
  output logic [WORD_W-1:0]  ramWdata,
  input  logic               cpuRdyWe,
  input  logic [IDX_W-1:0]   cpuRdyIdx,
  input  logic               cpuRdyVal,
  input  logic               cpuNdClr,
  input  logic [IDX_W-1:0]   cpuNdIdx,
  output logic [NUM_BUF-1:0] newData,
  output logic [NUM_BUF-1:0] updating,
  output logic [NUM_BUF-1:0] ready,
  input  logic               histPop,
  output logic               histValid,
  output logic [IDX_W-1:0]   histIdx,
  output logic               histOverflow,
  output logic               rxIrq
);
  storeCmd_t cmd;

  canRxStoreCtrl #(.DLC_W(DLC_W), .MAX_BYTES(MAX_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDlc(reqDlc),
    .cpuRamReq(cpuRamReq), .cmd(cmd), .busy(busy)
  );

  canRxStoreDpath #(
    .NUM_BUF(NUM_BUF), .ID_W(ID_W), .DLC_W(DLC_W), .MAX_BYTES(MAX_BYTES),
    .WORD_W(WORD_W), .HIST_DEPTH(HIST_DEPTH)
  ) uDpath (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .reqIdx(reqIdx), .reqId(reqId), .reqDlc(reqDlc), .reqData(reqData),
    .cpuRamReq(cpuRamReq), .cpuRamWe(cpuRamWe), .cpuRamAddr(cpuRamAddr),
    .cpuRamWdata(cpuRamWdata),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .cpuRdyWe(cpuRdyWe), .cpuRdyIdx(cpuRdyIdx), .cpuRdyVal(cpuRdyVal),
    .cpuNdClr(cpuNdClr), .cpuNdIdx(cpuNdIdx),
    .newData(newData), .updating(updating), .ready(ready),
    .histPop(histPop), .histValid(histValid), .histIdx(histIdx),
    .histOverflow(histOverflow), .rxIrq(rxIrq)
  );
endmodule

// File: rtl/canRxStoreSeqChk.sv
module canRxStoreSeqChk #(
  parameter int NUM_BUF = 32,
  parameter int ADDR_W  = 9,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [IDX_W-1:0]   reqIdx,
  input logic               busy,
  input logic               cpuRamReq,
  input logic               cpuRamWe,
  input logic [ADDR_W-1:0]  cpuRamAddr,
  input logic               ramWe,
  input logic [ADDR_W-1:0]  ramAddr,
  input logic               cpuRdyWe,
  input logic [IDX_W-1:0]   cpuRdyIdx,
  input logic [NUM_BUF-1:0] ready,
  input logic [NUM_BUF-1:0] newData,
  input logic [NUM_BUF-1:0] updating,
  input logic               rxIrq,
  input logic               histOverflow
);
  logic             accept;
  logic [IDX_W-1:0] lastIdx;

  assign accept = reqValid && !busy;

  always_ff @(posedge clk) begin
    if (!rstN)       lastIdx <= '0;
    else if (accept) lastIdx <= reqIdx;
  end

  p_start_flags_r2: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> newData[$past(reqIdx)] && updating[$past(reqIdx)]);

  p_done_flags_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> newData[lastIdx] && !updating[lastIdx]);

  p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);

  p_rdy_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdyWe && updating[cpuRdyIdx]) |=> ready[$past(cpuRdyIdx)] == $past(ready[cpuRdyIdx]));

  p_cpu_prio_r6: assert property (@(posedge clk) disable iff (!rstN)
    cpuRamReq |-> (ramWe == cpuRamWe) && (ramAddr == cpuRamAddr));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    histOverflow |=> histOverflow);

  p_single_store_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(updating));

  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy);
endmodule

bind canRxStoreSeq canRxStoreSeqChk #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIdx(reqIdx), .busy(busy),
  .cpuRamReq(cpuRamReq), .cpuRamWe(cpuRamWe), .cpuRamAddr(cpuRamAddr),
  .ramWe(ramWe), .ramAddr(ramAddr), .cpuRdyWe(cpuRdyWe), .cpuRdyIdx(cpuRdyIdx),
  .ready(ready), .newData(newData), .updating(updating), .rxIrq(rxIrq),
  .histOverflow(histOverflow)
);

// File: tb/tb_canRxStoreSeq.sv
module tb_canRxStoreSeq;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [4:0]  reqIdx;
  logic [10:0] reqId;
  logic [3:0]  reqDlc;
  logic [63:0] reqData;
  logic        busy;
  logic        cpuRamReq, cpuRamWe;
  logic [8:0]  cpuRamAddr;
  logic [15:0] cpuRamWdata;
  logic        ramEn, ramWe;
  logic [8:0]  ramAddr;
  logic [15:0] ramWdata;
  logic        cpuRdyWe, cpuRdyVal, cpuNdClr;
  logic [4:0]  cpuRdyIdx, cpuNdIdx;
  logic [31:0] newData, updating, ready;
  logic        histPop, histValid, histOverflow, rxIrq;
  logic [4:0]  histIdx;

  always #2 clk = ~clk;

  canRxStoreSeq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIdx(reqIdx), .reqId(reqId),
    .reqDlc(reqDlc), .reqData(reqData), .busy(busy),
    .cpuRamReq(cpuRamReq), .cpuRamWe(cpuRamWe), .cpuRamAddr(cpuRamAddr),
    .cpuRamWdata(cpuRamWdata), .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .cpuRdyWe(cpuRdyWe), .cpuRdyIdx(cpuRdyIdx),
    .cpuRdyVal(cpuRdyVal), .cpuNdClr(cpuNdClr), .cpuNdIdx(cpuNdIdx),
    .newData(newData), .updating(updating), .ready(ready),
    .histPop(histPop), .histValid(histValid), .histIdx(histIdx),
    .histOverflow(histOverflow), .rxIrq(rxIrq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Vector table: index, identifier, length code, data, stall mask per store cycle.
  localparam int NV = 6;
  localparam logic [4:0]  VIDX   [NV] = '{5'd3, 5'd31, 5'd0, 5'd17, 5'd9, 5'd31};
  localparam logic [10:0] VID    [NV] = '{11'h7FF, 11'h123, 11'h555, 11'h000, 11'h2AA, 11'h001};
  localparam logic [3:0]  VDLC   [NV] = '{4'd0, 4'd8, 4'd15, 4'd3, 4'd5, 4'd1};
  localparam logic [63:0] VDATA  [NV] = '{64'hDEAD_BEEF_0000_0001, 64'h8877_6655_4433_2211,
                                          64'hF0E1_D2C3_B4A5_9687, 64'h0000_0000_00CC_BBAA,
                                          64'h0102_0304_0506_0708, 64'hFFFF_FFFF_FFFF_FF5A};
  localparam logic [15:0] VSTALL [NV] = '{16'h0000, 16'h0000, 16'h0005, 16'h0038, 16'h0001, 16'h0003};

  function automatic logic [15:0] expWord(input int s, input logic [10:0] id,
                                          input logic [3:0] dlc, input logic [63:0] d);
    if (s == 0) return {5'b0, id};
    if (s == 1) return {12'b0, dlc};
    return {8'b0, d[(s-2)*8 +: 8]};
  endfunction

  function automatic int nWords(input logic [3:0] dlc);
    return 2 + ((dlc > 4'd8) ? 8 : int'(dlc));
  endfunction

  task automatic idleInputs();
    reqValid = 0; reqIdx = 0; reqId = 0; reqDlc = 0; reqData = 0;
    cpuRamReq = 0; cpuRamWe = 0; cpuRamAddr = 0; cpuRamWdata = 0;
    cpuRdyWe = 0; cpuRdyIdx = 0; cpuRdyVal = 0; cpuNdClr = 0; cpuNdIdx = 0;
    histPop = 0;
  endtask

  // Plain store with no stalls; returns when rxIrq is seen.
  task automatic quickStore(input logic [4:0] idx, input logic [3:0] dlc);
    @(negedge clk);
    reqValid = 1; reqIdx = idx; reqId = 11'h10; reqDlc = dlc; reqData = '0;
    @(negedge clk);
    reqValid = 0;
    for (int w = 0; w < 40 && !rxIrq; w++) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idleInputs();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R12: reset state
    chk(newData == 0 && updating == 0 && ready == 0, "R12 flags", {newData, updating}, 0);
    chk(!busy && !rxIrq && !histValid && !histOverflow, "R12 status",
        {busy, rxIrq, histValid, histOverflow}, 0);

    // Vector walk: R1 R2 R6 R7 R8 R3
    for (int v = 0; v < NV; v++) begin
      int expCyc, w, cyc, s, bad;
      w = 0; expCyc = 0;
      while (w < nWords(VDLC[v])) begin
        if (!VSTALL[v][expCyc]) w++;
        expCyc++;
      end
      reqValid = 1; reqIdx = VIDX[v]; reqId = VID[v]; reqDlc = VDLC[v]; reqData = VDATA[v];
      @(negedge clk);
      reqValid = 0;
      chk(newData[VIDX[v]] && updating[VIDX[v]] && busy, "R2 start flags",
          {newData[VIDX[v]], updating[VIDX[v]], busy}, 3'b111);
      cyc = 0; s = 0; bad = 0;
      while (!rxIrq && cyc < 40) begin
        cpuRamReq = VSTALL[v][cyc];
        cpuRamWe = 1; cpuRamAddr = 9'h1A5; cpuRamWdata = 16'hC0DE;
        #1;
        if (cpuRamReq) begin
          if (!(ramEn && ramWe && ramAddr == 9'h1A5 && ramWdata == 16'hC0DE)) bad++;
        end else begin
          // R1: address is {index, slot}; R7: word content per slot
          if (!(ramWe && ramAddr == {VIDX[v], 4'(s)} &&
                ramWdata == expWord(s, VID[v], VDLC[v], VDATA[v]))) bad++;
          s++;
        end
        @(negedge clk);
        cyc++;
      end
      cpuRamReq = 0;
      chk(bad == 0, "R7 R6 ram port words", bad, 0);
      chk(s == nWords(VDLC[v]), "R8 word count", s, nWords(VDLC[v]));
      chk(cyc == expCyc, "R6 completion cycle", cyc, expCyc);
      chk(rxIrq && newData[VIDX[v]] && !updating[VIDX[v]] && !busy, "R3 completion",
          {rxIrq, newData[VIDX[v]], updating[VIDX[v]], busy}, 4'b1100);
      @(negedge clk);
      chk(!rxIrq, "R3 irq single pulse", rxIrq, 0);
    end

    // R4: history order
    for (int v = 0; v < NV; v++) begin
      #1;
      chk(histValid && histIdx == VIDX[v], "R4 history order", histIdx, VIDX[v]);
      histPop = 1;
      @(negedge clk);
      histPop = 0;
    end
    chk(!histValid, "R4 history empty", histValid, 0);

    // Directed: CPU flag access during an update; request while busy
    reqValid = 1; reqIdx = 5'd12; reqId = 11'h3C; reqDlc = 4'd8; reqData = 64'h1;
    @(negedge clk);
    reqValid = 0;
    chk(histValid && histIdx == 5'd12 && updating[12], "R4 history while updating",
        {histValid, histIdx, updating[12]}, {1'b1, 5'd12, 1'b1});
    cpuRdyWe = 1; cpuRdyIdx = 5'd12; cpuRdyVal = 1;
    cpuNdClr = 1; cpuNdIdx = 5'd12;
    reqValid = 1; reqIdx = 5'd20; reqDlc = 4'd0;
    @(negedge clk);
    cpuRdyWe = 0; cpuNdClr = 0; reqValid = 0;
    chk(!ready[12], "R5 ready write ignored while updating", ready[12], 0);
    chk(newData[12], "R9 clear ignored while updating", newData[12], 1);
    for (int w = 0; w < 40 && !rxIrq; w++) @(negedge clk);
    chk(!newData[20] && !updating[20], "R11 request while busy dropped",
        {newData[20], updating[20]}, 0);
    cpuRdyWe = 1; cpuRdyIdx = 5'd12; cpuRdyVal = 1;
    cpuNdClr = 1; cpuNdIdx = 5'd12;
    @(negedge clk);
    cpuRdyWe = 0; cpuNdClr = 0;
    chk(ready[12], "R5 ready write when idle", ready[12], 1);
    chk(!newData[12], "R9 clear when idle", newData[12], 0);
    #1;
    chk(histValid && histIdx == 5'd12, "R11 only one history entry", histIdx, 12);
    histPop = 1;
    @(negedge clk);
    histPop = 0;
    chk(!histValid, "R11 busy request not logged", histValid, 0);

    // R9: clear in the same cycle as acceptance of that buffer
    reqValid = 1; reqIdx = 5'd7; reqDlc = 4'd0; cpuNdClr = 1; cpuNdIdx = 5'd7;
    @(negedge clk);
    reqValid = 0; cpuNdClr = 0;
    chk(newData[7], "R9 accept wins over clear", newData[7], 1);
    for (int w = 0; w < 40 && !rxIrq; w++) @(negedge clk);
    histPop = 1;
    @(negedge clk);
    histPop = 0;

    // R10: overflow
    for (int n = 0; n < 9; n++) quickStore(5'(n + 1), 4'd0);
    @(negedge clk);
    chk(histOverflow, "R10 overflow set", histOverflow, 1);
    begin
      int popped;
      popped = 0;
      #1;
      chk(histIdx == 5'd1, "R10 oldest kept", histIdx, 1);
      while (histValid && popped < 20) begin
        histPop = 1;
        @(negedge clk);
        popped++;
        #1;
      end
      histPop = 0;
      chk(popped == 8, "R10 depth eight", popped, 8);
    end
    @(negedge clk);
    chk(histOverflow, "R10 overflow sticky", histOverflow, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule